// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides whether a two-word conditional jump is taken, and it computes the program address that follows. It receives a 4-bit condition selector, three processor flags (accumulator is zero, carry, and the raw level of the external test input), the 12-bit address of the jump instruction, and the 8-bit in-page target from the second instruction word. It drives a taken flag and the next 12-bit address, with no clock between inputs and outputs.

The flags that the selector enables are OR-combined, and a selector bit can invert the result. A jump that is not taken steps past both instruction words. A taken jump keeps a page nibble and replaces the low byte with the target. The page comes from the address that follows the instruction. As a result, a jump at offset 254 or 255 of a page lands on the next page. The target former is a separate submodule, so a loop-count branch can reuse it.

Top module: `branch_decide`

## Requirements
- R1: The selector `cond_i` has these bits: bit 3 inverts the result, bit 2 enables the accumulator-is-zero test, bit 1 enables the carry-is-one test, and bit 0 enables the test-input-is-low test. The raw condition is the OR of every enabled test that holds.
- R2: `taken_o` equals the raw condition XOR `cond_i[3]`.
- R3: When `taken_o` is 0, `next_addr_o` equals `instr_addr_i + 2` modulo 4096.
- R4: When `taken_o` is 1, `next_addr_o[7:0]` equals `target_i`.
- R5: When `taken_o` is 1, `next_addr_o[11:8]` equals bits 11:8 of `instr_addr_i + 2` modulo 4096. So offsets 254 and 255 select the next page, and page 15 wraps to page 0.
- R6: When `cond_i[2:0]` is 000, `taken_o` equals `cond_i[3]`: an unconditional jump or a jump that is never taken.
- R7: A flag whose enable bit is 0 has no effect on `taken_o` or `next_addr_o`.
- R8: The outputs follow the inputs combinationally, with no clock edge between a change at the inputs and the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 4 | Condition selector: {invert, acc-zero enable, carry enable, test-low enable} |
| acc_zero_i | input | 1 | Accumulator holds zero |
| carry_i | input | 1 | Carry flag |
| test_i | input | 1 | Raw level of the external test input (the test counts as true when low) |
| instr_addr_i | input | 12 | Address of the first word of the jump |
| target_i | input | 8 | In-page target from the second word |
| taken_o | output | 1 | The jump is taken |
| next_addr_o | output | 12 | Address of the next instruction |

## Verification
A table of vectors tries each enable on its own with its flag active and inactive, combinations of enables in which only one flag or all flags are active, and the inverted forms of each. These separate the OR combination from an AND combination and show that inversion applies after the OR. The addresses are placed in mid-page, at offsets 253, 254 and 255, and at the top of the address space. This separates paging from the incremented address from paging from the instruction address, and it shows the wrap to page 0. A full sweep of selector and flag values at one address checks every combination against the requirement formula. A directed step changes the inputs between clock edges to show that the outputs are combinational.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

    localparam int ADDR_W = 12;
    localparam int OFS_W  = 8;
    localparam int STEP   = 2;
    localparam int NTEST  = 3;

    // Selector layout: the bit order is decoded by the instruction format.
    typedef struct packed {
        logic invert;
        logic on_acc_zero;
        logic on_carry;
        logic on_test_low;
    } cond_sel_t;

    typedef struct packed {
        logic acc_zero;
        logic carry;
        logic test_low;
    } flag_set_t;

    function automatic logic [NTEST-1:0] enables_of(cond_sel_t s);
        return {s.on_acc_zero, s.on_carry, s.on_test_low};
    endfunction

    function automatic logic [NTEST-1:0] levels_of(flag_set_t f);
        return {f.acc_zero, f.carry, f.test_low};
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import brdec_pkg::*;
(
    input  cond_sel_t sel_i,
    input  flag_set_t flags_i,
    output logic      taken_o
);
    logic [NTEST-1:0] en;
    logic [NTEST-1:0] lvl;
    logic [NTEST-1:0] hit;
    logic             raw;

    assign en  = enables_of(sel_i);
    assign lvl = levels_of(flags_i);

    for (genvar g = 0; g < NTEST; g++) begin : g_hit
        assign hit[g] = en[g] & lvl[g];
    end

    assign raw     = |hit;
    assign taken_o = raw ^ sel_i.invert;
endmodule

// File: rtl/seq_addr.sv
module seq_addr #(
    parameter int ADDR_W = brdec_pkg::ADDR_W,
    parameter int STEP   = brdec_pkg::STEP
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] seq_o
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);
    assign seq_o = addr_i + INC;
endmodule

// File: rtl/page_target.sv
module page_target #(
    parameter int ADDR_W = brdec_pkg::ADDR_W,
    parameter int OFS_W  = brdec_pkg::OFS_W
) (
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    logic [PAGE_W-1:0] page;

    assign page  = seq_i[ADDR_W-1:OFS_W];
    assign tgt_o = {page, ofs_i};
endmodule

// File: rtl/branch_decide.sv
module branch_decide
    import brdec_pkg::*;
#(
    parameter int AW = brdec_pkg::ADDR_W,
    parameter int OW = brdec_pkg::OFS_W
) (
    input  logic [3:0]    cond_i,
    input  logic          acc_zero_i,
    input  logic          carry_i,
    input  logic          test_i,
    input  logic [AW-1:0] instr_addr_i,
    input  logic [OW-1:0] target_i,
    output logic          taken_o,
    output logic [AW-1:0] next_addr_o
);
    cond_sel_t     sel;
    flag_set_t     flags;
    logic          take;
    logic [AW-1:0] seq;
    logic [AW-1:0] jump_addr;

    assign sel   = cond_sel_t'(cond_i);
    assign flags = '{acc_zero: acc_zero_i, carry: carry_i, test_low: ~test_i};

    cond_eval u_eval (
        .sel_i   (sel),
        .flags_i (flags),
        .taken_o (take)
    );

    seq_addr #(.ADDR_W(AW), .STEP(STEP)) u_seq (
        .addr_i (instr_addr_i),
        .seq_o  (seq)
    );

    page_target #(.ADDR_W(AW), .OFS_W(OW)) u_tgt (
        .seq_i (seq),
        .ofs_i (target_i),
        .tgt_o (jump_addr)
    );

    assign taken_o     = take;
    assign next_addr_o = take ? jump_addr : seq;
endmodule

// File: rtl/branch_decide_chk.sv
module branch_decide_chk (
    input logic [3:0]  cond_i,
    input logic        acc_zero_i,
    input logic        carry_i,
    input logic        test_i,
    input logic [11:0] instr_addr_i,
    input logic [7:0]  target_i,
    input logic        taken_o,
    input logic [11:0] next_addr_o
);
    logic [11:0] after;
    assign after = instr_addr_i + 12'd2;

    always_comb begin
        // R3
        fall_through_chk: assert (taken_o || next_addr_o == after);
        // R4
        target_low_chk: assert (!taken_o || next_addr_o[7:0] == target_i);
        // R5
        target_page_chk: assert (!taken_o || next_addr_o[11:8] == after[11:8]);
        // R6
        bare_invert_chk: assert (cond_i[2:0] != 3'b000 || taken_o == cond_i[3]);
        // R1
        acc_hit_chk: assert (!(cond_i[2] && acc_zero_i) || taken_o == !cond_i[3]);
        // R2
        test_hit_chk: assert (!(cond_i[0] && !test_i) || taken_o == !cond_i[3]);
    end
endmodule

bind branch_decide branch_decide_chk u_chk (
    .cond_i       (cond_i),
    .acc_zero_i   (acc_zero_i),
    .carry_i      (carry_i),
    .test_i       (test_i),
    .instr_addr_i (instr_addr_i),
    .target_i     (target_i),
    .taken_o      (taken_o),
    .next_addr_o  (next_addr_o)
);

// File: tb/test_branch_decide.sv
module test_branch_decide;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cond_i = '0;
    logic        acc_zero_i = 1'b0;
    logic        carry_i = 1'b0;
    logic        test_i = 1'b1;
    logic [11:0] instr_addr_i = '0;
    logic [7:0]  target_i = '0;
    logic        taken_o;
    logic [11:0] next_addr_o;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_decide i_branch_decide (
        .cond_i, .acc_zero_i, .carry_i, .test_i,
        .instr_addr_i, .target_i, .taken_o, .next_addr_o
    );

    // {req, cond, az, cy, test, addr, target, exp_taken, exp_next}
    localparam int NV = 17;
    localparam logic [43:0] VEC [NV] = '{
        {4'd6, 4'b0000, 3'b001, 12'h100, 8'h55, 1'b0, 12'h102}, // R6 never
        {4'd6, 4'b1000, 3'b001, 12'h100, 8'h55, 1'b1, 12'h155}, // R6 always
        {4'd1, 4'b0100, 3'b101, 12'h234, 8'h10, 1'b1, 12'h210}, // R1 acc zero
        {4'd3, 4'b0100, 3'b001, 12'h234, 8'h10, 1'b0, 12'h236}, // R3
        {4'd1, 4'b0010, 3'b011, 12'h3A0, 8'hFF, 1'b1, 12'h3FF}, // R1 carry
        {4'd1, 4'b0001, 3'b000, 12'h400, 8'h01, 1'b1, 12'h401}, // R1 test low
        {4'd3, 4'b0001, 3'b001, 12'h400, 8'h01, 1'b0, 12'h402}, // R3 test high
        {4'd2, 4'b1100, 3'b101, 12'h500, 8'h20, 1'b0, 12'h502}, // R2 inverted hit
        {4'd2, 4'b1110, 3'b000, 12'h600, 8'h33, 1'b1, 12'h633}, // R2 inverted miss
        {4'd5, 4'b0110, 3'b011, 12'h7FE, 8'h44, 1'b1, 12'h844}, // R5 offset 254
        {4'd5, 4'b0111, 3'b101, 12'h7FF, 8'h08, 1'b1, 12'h808}, // R5 offset 255
        {4'd3, 4'b0000, 3'b001, 12'h7FE, 8'h44, 1'b0, 12'h800}, // R3 page step
        {4'd5, 4'b1000, 3'b001, 12'hFFE, 8'h12, 1'b1, 12'h012}, // R5 wrap
        {4'd3, 4'b0000, 3'b001, 12'hFFF, 8'h12, 1'b0, 12'h001}, // R3 wrap
        {4'd2, 4'b1111, 3'b110, 12'h0FD, 8'h77, 1'b0, 12'h0FF}, // R2 all hit
        {4'd7, 4'b0111, 3'b001, 12'h0FD, 8'h77, 1'b0, 12'h0FF}, // R7 no flag active
        {4'd4, 4'b1000, 3'b001, 12'h0FD, 8'h77, 1'b1, 12'h077}  // R4 offset 253
    };

    task automatic check(input string req, input logic et, input logic [11:0] en);
        applied++;
        if (taken_o !== et || next_addr_o !== en) begin
            bad++;
            $display("FAIL %s: taken=%b next=%h expected taken=%b next=%h",
                     req, taken_o, next_addr_o, et, en);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [2:0] f,
                         input logic [11:0] a, input logic [7:0] t);
        cond_i = c; acc_zero_i = f[2]; carry_i = f[1]; test_i = f[0];
        instr_addr_i = a; target_i = t;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            applied++; bad++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R3 state after reset with idle inputs
        check("R3", 1'b0, 12'h002);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][39:36], VEC[i][35:33], VEC[i][32:21], VEC[i][20:13]);
            #1;
            check($sformatf("R%0d", VEC[i][43:40]), VEC[i][12], VEC[i][11:0]);
        end

        // R2 sweep of every selector and flag value, expected from the formula
        for (int k = 0; k < 128; k++) begin
            logic [3:0] c;
            logic [2:0] f;
            logic raw;
            logic et;
            c = k[6:3]; f = k[2:0];
            raw = (c[2] & f[2]) | (c[1] & f[1]) | (c[0] & ~f[0]);
            et = raw ^ c[3];
            @(negedge clk);
            drive(c, f, 12'h3C5, 8'hA9);
            #1;
            check("R2", et, et ? 12'h3A9 : 12'h3C7);
        end

        // R8 result changes between edges with no clock edge in between
        @(posedge clk); #2;
        drive(4'b0010, 3'b001, 12'h9FE, 8'h5A);
        #1 check("R8", 1'b0, 12'hA00);
        carry_i = 1'b1;
        #1 check("R8", 1'b1, 12'hA5A);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule